// File: doc/BRIEF.md
# Rate Sample Output Register Unit

This unit sits between a rate-sensing datapath and a serial register-access front end. Each incoming signed 16-bit rate sample, flagged by a one-cycle valid strobe, is formatted and placed in a pair of byte-wide output registers (upper byte and lower byte). Next to them sits a status byte. It carries one new-data flag per byte and an overrun flag. A serial host reads all three through byte-addressed read strobes.

Two control bits shape the behaviour. The lock bit freezes the output pair until the host has read both bytes of the value it holds. A sample that arrives while the pair is frozen is kept in a one-entry pending slot, and a newer sample replaces it there. The alignment bit chooses the format applied at load time: either the full 16-bit value, or a 10-bit value taken from the top of the sample and sign-extended to 16 bits. The sample input has a valid strobe only. The unit accepts every strobe and never applies back-pressure, because under lock the pending slot absorbs the excess by keeping only the newest sample.

Top module: `rate_out_regs`

## Requirements
- R1: After reset the upper byte, the lower byte and the status byte all read 0x00.
- R2: With the lock bit at 0, a valid sample is loaded at the clock edge where its strobe is high. From that edge on, both new-data flags read 1.
- R3: With the alignment bit at 0, the upper byte equals sample bits 15:8 and the lower byte equals sample bits 7:0.
- R4: With the alignment bit at 1, the 16-bit output pair equals the two's-complement sample divided by 64 and rounded toward minus infinity, so bits 15:9 all copy the sign.
- R5: A read strobe at address 0x28 clears the upper-byte flag (status bit 1), and one at address 0x29 clears the lower-byte flag (status bit 0). A load in the same cycle wins and sets the flags.
- R6: The status byte is {5'b0, overrun, upper-new, lower-new}, with overrun at bit 2, upper-new at bit 1 and lower-new at bit 0, and it is read at address 0x27.
- R7: The overrun flag is set by a load that happens while either new-data flag is 1. A read strobe at 0x27 clears it, and a set in the same cycle wins.
- R8: With the lock bit at 1, the output pair does not change while either new-data flag is 1, and the overrun flag is not set.
- R9: Under lock, the newest sample that arrived while the pair was frozen is loaded one clock after the read that clears the last new-data flag. Earlier frozen samples are discarded.
- R10: Under lock, a read of the status byte does not release the frozen pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 16 | Signed rate sample |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| cfg_lock | input | 1 | 1: freeze the pair until both bytes are read |
| cfg_rjust | input | 1 | 0: 16-bit left-justified; 1: 10-bit right-justified, sign-extended |
| rd_en | input | 1 | Read strobe from the host front end |
| rd_addr | input | 8 | Byte address of the read |
| reg_hi | output | 8 | Upper output byte |
| reg_lo | output | 8 | Lower output byte |
| reg_stat | output | 8 | Status byte |

## Verification
Two sweeps of several hundred spread sample values, plus corner values (most negative, most positive, minus one, and values just above and below a multiple of 64), are loaded with each alignment setting. They separate a byte swap, a logical shift in place of an arithmetic one, and an off-by-one shift amount. Read sequences covering each byte address alone, back-to-back loads without reads, and a read in the same cycle as a load tell apart flag clearing, flag-set priority and overrun detection. A locked run pushes three samples, reads the status byte and then both data bytes. It shows whether the pair stays frozen, whether a status read wrongly releases it, and whether the newest sample (not the first frozen one) is loaded exactly one cycle after the release.

// File: rtl/rate_out_pkg.sv
package rate_out_pkg;

  typedef struct packed {
    logic ovr;
    logic hi_new;
    logic lo_new;
  } rate_flags_t;

endpackage

// File: rtl/rate_out_fmt.sv
module rate_out_fmt #(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 10
) (
  input  logic [SAMPLE_W-1:0] raw,
  input  logic                rjust,
  output logic [SAMPLE_W-1:0] fmt
);
  localparam int SHIFT = SAMPLE_W - NARROW_W;

  logic [SAMPLE_W-1:0] narrow;

  generate
    if (SHIFT > 0) begin : g_shift
      assign narrow = {{SHIFT{raw[SAMPLE_W-1]}}, raw[SAMPLE_W-1:SHIFT]};
    end else begin : g_pass
      assign narrow = raw;
    end
  endgenerate

  assign fmt = rjust ? narrow : raw;
endmodule

// File: rtl/rate_out_hold.sv
module rate_out_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                locked,
  output logic                ld,
  output logic [SAMPLE_W-1:0] ld_data
);
  logic                pend_v;
  logic [SAMPLE_W-1:0] pend_d;

  assign ld      = (in_valid | pend_v) & ~locked;
  assign ld_data = in_valid ? in_data : pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (in_valid && locked) begin
      pend_v <= 1'b1;
      pend_d <= in_data;
    end else if (ld) begin
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_out_flags.sv
module rate_out_flags
  import rate_out_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic        rd_hi,
  input  logic        rd_lo,
  input  logic        rd_st,
  output rate_flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (ld)         flags.hi_new <= 1'b1;
      else if (rd_hi) flags.hi_new <= 1'b0;

      if (ld)         flags.lo_new <= 1'b1;
      else if (rd_lo) flags.lo_new <= 1'b0;

      if (ld && (flags.hi_new || flags.lo_new)) flags.ovr <= 1'b1;
      else if (rd_st)                           flags.ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_out_regs.sv
module rate_out_regs
  import rate_out_pkg::*;
#(
  parameter int          SAMPLE_W = 16,
  parameter int          NARROW_W = 10,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  ADDR_ST  = 8'h27,
  parameter logic [7:0]  ADDR_HI  = 8'h28,
  parameter logic [7:0]  ADDR_LO  = 8'h29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         smp_data,
  input  logic                smp_valid,
  input  logic                cfg_lock,
  input  logic                cfg_rjust,
  input  logic                rd_en,
  input  logic [7:0]          rd_addr,
  output logic [7:0]          reg_hi,
  output logic [7:0]          reg_lo,
  output logic [7:0]          reg_stat
);
  localparam int BYTE_W = SAMPLE_W / 2;

  rate_flags_t         flags;
  logic                locked;
  logic                ld;
  logic [SAMPLE_W-1:0] ld_raw;
  logic [SAMPLE_W-1:0] ld_fmt;
  logic [SAMPLE_W-1:0] out_q;
  logic                rd_hi, rd_lo, rd_st;

  assign rd_hi = rd_en && (rd_addr == ADDR_W'(ADDR_HI));
  assign rd_lo = rd_en && (rd_addr == ADDR_W'(ADDR_LO));
  assign rd_st = rd_en && (rd_addr == ADDR_W'(ADDR_ST));

  assign locked = cfg_lock & (flags.hi_new | flags.lo_new);

  rate_out_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .locked   (locked),
    .ld       (ld),
    .ld_data  (ld_raw)
  );

  rate_out_fmt #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_fmt (
    .raw   (ld_raw),
    .rjust (cfg_rjust),
    .fmt   (ld_fmt)
  );

  rate_out_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld),
    .rd_hi (rd_hi),
    .rd_lo (rd_lo),
    .rd_st (rd_st),
    .flags (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_q <= '0;
    else if (ld) out_q <= ld_fmt;
  end

  assign reg_hi   = out_q[SAMPLE_W-1:BYTE_W];
  assign reg_lo   = out_q[BYTE_W-1:0];
  assign reg_stat = {5'b0, flags.ovr, flags.hi_new, flags.lo_new};
endmodule

// File: rtl/rate_out_regs_chk.sv
module rate_out_regs_chk #(
  parameter logic [7:0] ADDR_ST = 8'h27,
  parameter logic [7:0] ADDR_HI = 8'h28,
  parameter logic [7:0] ADDR_LO = 8'h29
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] smp_data,
  input logic        smp_valid,
  input logic        cfg_lock,
  input logic        cfg_rjust,
  input logic        rd_en,
  input logic [7:0]  rd_addr,
  input logic [7:0]  reg_hi,
  input logic [7:0]  reg_lo,
  input logic [7:0]  reg_stat,
  input logic        ld
);
  // R2
  unlocked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_lock && smp_valid) |=> ({reg_hi, reg_lo} ==
      ($past(cfg_rjust) ? {{6{$past(smp_data[15])}}, $past(smp_data[15:6])}
                        : $past(smp_data))));

  // R2
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (reg_stat[1:0] == 2'b11));

  // R4
  rjust_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && cfg_rjust) |=> (reg_hi[7:1] == {7{reg_hi[1]}}));

  // R5
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_HI && !ld) |=> !reg_stat[1]);

  // R5
  lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_LO && !ld) |=> !reg_stat[0]);

  // R6
  stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stat[7:3] == 5'b0);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && reg_stat[1:0] != 2'b00) |=> reg_stat[2]);

  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_ST && !(ld && reg_stat[1:0] != 2'b00)) |=> !reg_stat[2]);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lock && reg_stat[1:0] != 2'b00) |=> ($stable(reg_hi) && $stable(reg_lo)));
endmodule

bind rate_out_regs rate_out_regs_chk #(
  .ADDR_ST (ADDR_ST),
  .ADDR_HI (ADDR_HI),
  .ADDR_LO (ADDR_LO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_data  (smp_data),
  .smp_valid (smp_valid),
  .cfg_lock  (cfg_lock),
  .cfg_rjust (cfg_rjust),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .reg_hi    (reg_hi),
  .reg_lo    (reg_lo),
  .reg_stat  (reg_stat),
  .ld        (ld)
);

// File: tb/sim_rate_out_regs.sv
module sim_rate_out_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        cfg_lock = 1'b0;
  logic        cfg_rjust = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  reg_hi, reg_lo, reg_stat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rate_out_regs u0 (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .cfg_lock(cfg_lock), .cfg_rjust(cfg_rjust), .rd_en(rd_en), .rd_addr(rd_addr),
    .reg_hi(reg_hi), .reg_lo(reg_lo), .reg_stat(reg_stat)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] expect_fmt(logic [15:0] d, logic rj);
    int v, r;
    v = int'($signed(d));
    r = v - (((v % 64) + 64) % 64);
    return rj ? 16'(r / 64) : d;
  endfunction

  task automatic push(logic [15:0] d);
    smp_data  = d;
    smp_valid = 1'b1;
    step();
    smp_valid = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    rd_en   = 1'b1;
    rd_addr = a;
    step();
    rd_en   = 1'b0;
  endtask

  task automatic sweep(logic rj);
    logic [15:0] corners [8];
    corners = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000,
                16'h0040, 16'h003F, 16'hFFC0, 16'hFFBF};
    cfg_rjust = rj;
    for (int i = 0; i < 8; i++) begin
      push(corners[i]);
      check(rj ? "R4 corner" : "R3 corner", {reg_hi, reg_lo}, expect_fmt(corners[i], rj));
    end
    for (int i = 0; i < 300; i++) begin
      logic [15:0] d;
      d = 16'((i * 40503 + 17) & 16'hFFFF);
      push(d);
      check(rj ? "R4 sweep" : "R3 sweep", {reg_hi, reg_lo}, expect_fmt(d, rj));
    end
    check("R2 flags after load", {8'h0, reg_stat & 8'h03}, 16'h0003);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    // R1
    check("R1 hi", {8'h0, reg_hi}, 16'h0000);
    check("R1 lo", {8'h0, reg_lo}, 16'h0000);
    check("R1 stat", {8'h0, reg_stat}, 16'h0000);
    rst_n = 1'b1;
    step();

    sweep(1'b0);
    sweep(1'b1);
    cfg_rjust = 1'b0;

    // R5 / R7 / R6: flag clearing and overrun
    check("R7 overrun after sweep", {8'h0, reg_stat}, 16'h0007);
    rd(8'h28);
    check("R5 hi read clears bit1", {8'h0, reg_stat}, 16'h0005);
    rd(8'h29);
    check("R5 lo read clears bit0", {8'h0, reg_stat}, 16'h0004);
    rd(8'h27);
    check("R7 status read clears overrun", {8'h0, reg_stat}, 16'h0000);
    push(16'h1234);
    check("R2 single load flags", {8'h0, reg_stat}, 16'h0003);
    rd(8'h29);
    check("R5 lo read only", {8'h0, reg_stat}, 16'h0002);
    rd(8'h30);
    check("R6 other address no effect", {8'h0, reg_stat}, 16'h0002);
    rd(8'h28);
    check("R6 status all clear", {8'h0, reg_stat}, 16'h0000);
    push(16'h1111);
    push(16'h2222);
    check("R7 back-to-back overrun", {8'h0, reg_stat}, 16'h0007);
    rd(8'h27);
    check("R7 clear keeps new flags", {8'h0, reg_stat}, 16'h0003);
    rd_en = 1'b1; rd_addr = 8'h28;
    push(16'h3333);
    rd_en = 1'b0;
    check("R5 load wins over read", {8'h0, reg_stat}, 16'h0007);
    check("R3 same-cycle data", {reg_hi, reg_lo}, 16'h3333);
    rd_en = 1'b1; rd_addr = 8'h27;
    push(16'h4444);
    rd_en = 1'b0;
    check("R7 set wins over clear", {8'h0, reg_stat}, 16'h0007);
    rd(8'h28); rd(8'h29); rd(8'h27);
    check("R6 cleared", {8'h0, reg_stat}, 16'h0000);

    // R8 / R9 / R10: locked behaviour
    cfg_lock = 1'b1;
    push(16'hA001);
    check("R8 first load under lock", {reg_hi, reg_lo}, 16'hA001);
    push(16'hB002);
    push(16'hC003);
    check("R8 pair frozen", {reg_hi, reg_lo}, 16'hA001);
    check("R8 no overrun under lock", {8'h0, reg_stat}, 16'h0003);
    rd(8'h27);
    check("R10 status read keeps pair", {reg_hi, reg_lo}, 16'hA001);
    check("R10 flags kept", {8'h0, reg_stat}, 16'h0003);
    rd(8'h28);
    check("R8 one half read still frozen", {reg_hi, reg_lo}, 16'hA001);
    rd(8'h29);
    check("R9 not yet loaded at release", {reg_hi, reg_lo}, 16'hA001);
    check("R9 flags clear at release", {8'h0, reg_stat}, 16'h0000);
    step();
    check("R9 newest pending loaded", {reg_hi, reg_lo}, 16'hC003);
    check("R9 flags after pending load", {8'h0, reg_stat}, 16'h0003);
    step();
    check("R9 older pending discarded", {reg_hi, reg_lo}, 16'hC003);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule